// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block holds the current time of day as a chain of four decimal counters: seconds, minutes, hours and a morning/afternoon flag. A single-cycle enable pulse, raised once per second by logic outside the block, advances the seconds. When a stage reaches its last value while advancing, it lets the next stage step on the same clock edge. Seconds and minutes run 00 to 59. Hours run 12, 01, 02 and so on up to 11, then back to 12. The morning/afternoon flag flips when hours go from 11 to 12.

Each of the four stages has its own clear, count-enable and load strobe. A shared eight-bit bus carries the preset value for any stage being loaded, which is how the time is set. Seconds, minutes and hours each come out as two packed BCD digits. Everything runs on one clock.

Top module: `clock_time_counter`

## Requirements
- R1: A synchronous active-low reset sets the time to 12:00:00 with the flag at 0 (morning); `pm` = 1 means afternoon.
- R2: With `tick_1hz` high and the seconds enable (`stage_ce[0]`) high, seconds advance by one in BCD. With `tick_1hz` low, nothing changes.
- R3: Seconds wrap from 59 to 00. On that same edge, minutes advance if `stage_ce[1]` is high.
- R4: Minutes wrap from 59 to 00 when seconds also wrap. On that same edge, hours advance if `stage_ce[2]` is high.
- R5: Hours follow 12, 01, ..., 09, 10, 11, 12 in packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R6: The flag toggles on the edge where hours step from 11 to 12, if `stage_ce[3]` is high. It does not toggle on any other hour step.
- R7: A stage whose enable is low holds its value and passes no carry, so the stages after it also hold. Enable bit order: [0] seconds, [1] minutes, [2] hours, [3] flag.
- R8: A clear on a stage forces seconds or minutes to 00, hours to 12, or the flag to 0. Clear overrides a load and a count on that stage, and the cleared stage passes no carry. Clear bits use the same order as the enables.
- R9: A load strobe writes `load_data` into its stage. The value is packed BCD, and the flag takes bit 0. A load overrides counting on that stage, and a loaded stage passes no carry. Several stages may load the same value at once. Load bits use the same order as the enables.
- R10: A load is ignored if either digit exceeds 9 or the value is out of range (00-59 for seconds and minutes, 01-12 for hours). An ignored load leaves that stage counting as if no strobe were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| stage_ce | input | 4 | Per-stage count enable: [0] sec, [1] min, [2] hour, [3] flag |
| stage_clr | input | 4 | Per-stage clear, same order |
| stage_ld | input | 4 | Per-stage load strobe, same order |
| load_data | input | 8 | Shared preset, packed BCD; flag uses bit 0 |
| sec_bcd | output | 8 | Seconds, two BCD digits |
| min_bcd | output | 8 | Minutes, two BCD digits |
| hour_bcd | output | 8 | Hours, two BCD digits |
| pm | output | 1 | 0 morning, 1 afternoon |

## Verification
Every stage's value is a port, so a wrong stored digit shows on the very next clock edge. A wrong carry decision shows on the edge where the stage wraps: a neighbour that steps too early, too late, or not at all. Hour and flag faults are the slowest to appear. A bad wrap of 11, 12 or 01, or a flag toggling at the wrong hour, can only be seen on the edge where hours change. For that reason the stimulus presets values next to each wrap point and also runs long stretches of continuous ticks.

// File: rtl/clk_time_pkg.sv
// Package: shared widths, stage indices and BCD helpers for the time counter.
// Assumes two BCD digits per stage, packed tens-high.
package clk_time_pkg;
    localparam int STAGE_N = 4;
    localparam int DIG_W   = 4;
    localparam int BCD_W   = 2 * DIG_W;
    localparam int IDX_SEC = 0;
    localparam int IDX_MIN = 1;
    localparam int IDX_HR  = 2;
    localparam int IDX_AP  = 3;

    // Integer 0..99 to packed BCD.
    function automatic logic [BCD_W-1:0] to_bcd(input int v);
        return {DIG_W'(v / 10), DIG_W'(v % 10)};
    endfunction

    // True when both nibbles are decimal digits.
    function automatic logic is_bcd(input logic [BCD_W-1:0] b);
        return (b[BCD_W-1:DIG_W] <= DIG_W'(9)) && (b[DIG_W-1:0] <= DIG_W'(9));
    endfunction

    // Packed BCD to integer.
    function automatic int bcd_val(input logic [BCD_W-1:0] b);
        return int'(b[BCD_W-1:DIG_W]) * 10 + int'(b[DIG_W-1:0]);
    endfunction
endpackage

// File: rtl/bcd_mod_stage.sv
// Module: one two-digit BCD counter stage with clear, load and enable.
// Counts LO..HI and wraps HI->LO; carry is raised when it advances out of TC_VAL.
// Assumes: clr > valid load > count; an invalid load is treated as absent.
module bcd_mod_stage
    import clk_time_pkg::*;
#(
    parameter int LO      = 0,
    parameter int HI      = 59,
    parameter int CLR_VAL = 0,
    parameter int TC_VAL  = 59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic             ce,
    input  logic             adv_in,
    input  logic [BCD_W-1:0] ld_data,
    output logic [BCD_W-1:0] value,
    output logic             carry
);
    localparam logic [BCD_W-1:0] LO_B     = to_bcd(LO);
    localparam logic [BCD_W-1:0] HI_B     = to_bcd(HI);
    localparam logic [BCD_W-1:0] CLR_B    = to_bcd(CLR_VAL);
    localparam logic [BCD_W-1:0] TC_B     = to_bcd(TC_VAL);
    localparam logic [BCD_W-1:0] AFTER_TC = to_bcd((TC_VAL == HI) ? LO : TC_VAL + 1);
    localparam logic [DIG_W-1:0] ONE      = DIG_W'(1);
    localparam logic [DIG_W-1:0] NINE     = DIG_W'(9);

    logic [BCD_W-1:0] cnt;
    logic [BCD_W-1:0] nxt;
    logic             ld_ok;
    logic             step;

    // Validity of the preset and whether this stage is asked to step.
    always_comb begin
        ld_ok = is_bcd(ld_data) && (bcd_val(ld_data) >= LO) && (bcd_val(ld_data) <= HI);
        step  = ce && adv_in;
    end

    // BCD increment with wrap from HI to LO.
    always_comb begin
        if (cnt == HI_B)
            nxt = LO_B;
        else if (cnt[DIG_W-1:0] == NINE)
            nxt = {cnt[BCD_W-1:DIG_W] + ONE, {DIG_W{1'b0}}};
        else
            nxt = {cnt[BCD_W-1:DIG_W], cnt[DIG_W-1:0] + ONE};
    end

    // Stage register: reset/clear, then load, then count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= CLR_B;
        else if (ld && ld_ok)
            cnt <= ld_data;
        else if (step)
            cnt <= nxt;
    end

    // Carry only when this stage really advances out of its terminal value.
    always_comb carry = step && !clr && !(ld && ld_ok) && (cnt == TC_B);

    assign value = cnt;

    AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        is_bcd(cnt) && (bcd_val(cnt) >= LO) && (bcd_val(cnt) <= HI)); // R10
    AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == CLR_B); // R8
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !step) |=> $stable(cnt)); // R7
    AST_STAGE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> cnt == AFTER_TC); // R3
endmodule

// File: rtl/ampm_stage.sv
// Module: morning/afternoon flag; toggles on each step, clear forces morning.
// Assumes: clr > load > toggle.
module ampm_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ld,
    input  logic ld_bit,
    input  logic step,
    output logic pm
);
    logic flag;

    // Flag register: reset/clear, then load, then toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            flag <= 1'b0;
        else if (ld)
            flag <= ld_bit;
        else if (step)
            flag <= ~flag;
    end

    assign pm = flag;

    AST_FLAG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !ld) |=> flag != $past(flag)); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr && !ld) |=> $stable(flag)); // R7
endmodule

// File: rtl/clock_time_counter.sv
// Module: twelve-hour time-of-day counter, seconds -> minutes -> hours -> flag.
// Assumes tick_1hz is a single-cycle enable in the clk domain.
module clock_time_counter
    import clk_time_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_1hz,
    input  logic [STAGE_N-1:0] stage_ce,
    input  logic [STAGE_N-1:0] stage_clr,
    input  logic [STAGE_N-1:0] stage_ld,
    input  logic [BCD_W-1:0]   load_data,
    output logic [BCD_W-1:0]   sec_bcd,
    output logic [BCD_W-1:0]   min_bcd,
    output logic [BCD_W-1:0]   hour_bcd,
    output logic               pm
);
    logic sec_carry;
    logic min_carry;
    logic hr_carry;
    logic ap_step;

    bcd_mod_stage #(.LO(0), .HI(59), .CLR_VAL(0), .TC_VAL(59)) u_sec (
        .clk(clk), .rst_n(rst_n),
        .clr(stage_clr[IDX_SEC]), .ld(stage_ld[IDX_SEC]), .ce(stage_ce[IDX_SEC]),
        .adv_in(tick_1hz), .ld_data(load_data),
        .value(sec_bcd), .carry(sec_carry)
    );

    bcd_mod_stage #(.LO(0), .HI(59), .CLR_VAL(0), .TC_VAL(59)) u_min (
        .clk(clk), .rst_n(rst_n),
        .clr(stage_clr[IDX_MIN]), .ld(stage_ld[IDX_MIN]), .ce(stage_ce[IDX_MIN]),
        .adv_in(sec_carry), .ld_data(load_data),
        .value(min_bcd), .carry(min_carry)
    );

    // Hours: 01..12, clear to 12, carry to the flag when leaving 11.
    bcd_mod_stage #(.LO(1), .HI(12), .CLR_VAL(12), .TC_VAL(11)) u_hr (
        .clk(clk), .rst_n(rst_n),
        .clr(stage_clr[IDX_HR]), .ld(stage_ld[IDX_HR]), .ce(stage_ce[IDX_HR]),
        .adv_in(min_carry), .ld_data(load_data),
        .value(hour_bcd), .carry(hr_carry)
    );

    // Flag steps only when enabled and hours leave 11.
    always_comb ap_step = stage_ce[IDX_AP] && hr_carry;

    ampm_stage u_ap (
        .clk(clk), .rst_n(rst_n),
        .clr(stage_clr[IDX_AP]), .ld(stage_ld[IDX_AP]), .ld_bit(load_data[0]),
        .step(ap_step), .pm(pm)
    );

    AST_HOUR_TO_TWELVE: assert property (@(posedge clk) disable iff (!rst_n)
        hr_carry |=> hour_bcd == 8'h12); // R6
    AST_MIN_NEEDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        min_carry |-> sec_carry); // R4
endmodule

// File: tb/clock_time_counter_test.sv
module clock_time_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [3:0] stage_ce = 4'h0;
    logic [3:0] stage_clr = 4'h0;
    logic [3:0] stage_ld = 4'h0;
    logic [7:0] load_data = 8'h00;
    logic [7:0] sec_bcd, min_bcd, hour_bcd;
    logic       pm;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clock_time_counter uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .stage_ce(stage_ce), .stage_clr(stage_clr), .stage_ld(stage_ld),
        .load_data(load_data), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
        .hour_bcd(hour_bcd), .pm(pm)
    );

    typedef struct packed {
        logic       tick;
        logic [3:0] ce;
        logic [3:0] clr;
        logic [3:0] ld;
        logic [7:0] data;
        logic [7:0] es;
        logic [7:0] em;
        logic [7:0] eh;
        logic       ep;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'hF, 4'h0, 4'h0, 8'h00, 8'h01, 8'h00, 8'h12, 1'b0, 4'd2},  // R2 count
        '{1'b0, 4'hF, 4'h0, 4'h0, 8'h00, 8'h01, 8'h00, 8'h12, 1'b0, 4'd2},  // R2 no tick
        '{1'b0, 4'hF, 4'h0, 4'h1, 8'h59, 8'h59, 8'h00, 8'h12, 1'b0, 4'd9},  // R9 load sec
        '{1'b1, 4'hF, 4'h0, 4'h0, 8'h00, 8'h00, 8'h01, 8'h12, 1'b0, 4'd3},  // R3 wrap
        '{1'b0, 4'hF, 4'h0, 4'h2, 8'h59, 8'h00, 8'h59, 8'h12, 1'b0, 4'd9},  // R9 load min
        '{1'b0, 4'hF, 4'h0, 4'h1, 8'h59, 8'h59, 8'h59, 8'h12, 1'b0, 4'd9},  // R9
        '{1'b1, 4'hF, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 4'd4},  // R4 12->01
        '{1'b0, 4'hF, 4'h0, 4'h4, 8'h09, 8'h00, 8'h00, 8'h09, 1'b0, 4'd9},  // R9 load hr
        '{1'b0, 4'hF, 4'h0, 4'h3, 8'h59, 8'h59, 8'h59, 8'h09, 1'b0, 4'd9},  // R9 multi
        '{1'b1, 4'hF, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h10, 1'b0, 4'd5},  // R5 09->10
        '{1'b0, 4'hF, 4'h0, 4'h4, 8'h11, 8'h00, 8'h00, 8'h11, 1'b0, 4'd9},  // R9
        '{1'b0, 4'hF, 4'h0, 4'h3, 8'h59, 8'h59, 8'h59, 8'h11, 1'b0, 4'd9},  // R9
        '{1'b1, 4'hF, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h12, 1'b1, 4'd6},  // R6 11->12 PM
        '{1'b1, 4'hF, 4'h0, 4'h1, 8'h30, 8'h30, 8'h00, 8'h12, 1'b1, 4'd9},  // R9 load beats count
        '{1'b0, 4'hF, 4'h0, 4'h1, 8'h60, 8'h30, 8'h00, 8'h12, 1'b1, 4'd10}, // R10 sec 60
        '{1'b0, 4'hF, 4'h0, 4'h4, 8'h13, 8'h30, 8'h00, 8'h12, 1'b1, 4'd10}, // R10 hr 13
        '{1'b0, 4'hF, 4'h0, 4'h4, 8'h00, 8'h30, 8'h00, 8'h12, 1'b1, 4'd10}, // R10 hr 00
        '{1'b0, 4'hF, 4'h0, 4'h2, 8'h5A, 8'h30, 8'h00, 8'h12, 1'b1, 4'd10}, // R10 digit A
        '{1'b1, 4'hF, 4'h0, 4'h1, 8'h5A, 8'h31, 8'h00, 8'h12, 1'b1, 4'd10}, // R10 counts on
        '{1'b0, 4'hF, 4'h0, 4'h3, 8'h59, 8'h59, 8'h59, 8'h12, 1'b1, 4'd9},  // R9
        '{1'b1, 4'hD, 4'h0, 4'h0, 8'h00, 8'h00, 8'h59, 8'h12, 1'b1, 4'd7},  // R7 min disabled
        '{1'b1, 4'hF, 4'h1, 4'h1, 8'h20, 8'h00, 8'h59, 8'h12, 1'b1, 4'd8},  // R8 clear beats load
        '{1'b0, 4'hF, 4'h0, 4'h8, 8'h00, 8'h00, 8'h59, 8'h12, 1'b0, 4'd9},  // R9 flag load 0
        '{1'b0, 4'hF, 4'h0, 4'h4, 8'h05, 8'h00, 8'h59, 8'h05, 1'b0, 4'd9},  // R9
        '{1'b0, 4'hF, 4'h0, 4'h8, 8'h01, 8'h00, 8'h59, 8'h05, 1'b1, 4'd9},  // R9 flag load 1
        '{1'b0, 4'hF, 4'hE, 4'h8, 8'h01, 8'h00, 8'h00, 8'h12, 1'b0, 4'd8},  // R8 clears
        '{1'b0, 4'hF, 4'h0, 4'h4, 8'h11, 8'h00, 8'h00, 8'h11, 1'b0, 4'd9},  // R9
        '{1'b0, 4'hF, 4'h0, 4'h3, 8'h59, 8'h59, 8'h59, 8'h11, 1'b0, 4'd9},  // R9
        '{1'b1, 4'h7, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h12, 1'b0, 4'd7},  // R7 flag disabled
        '{1'b1, 4'hE, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h12, 1'b0, 4'd7}   // R7 sec disabled
    };

    task automatic check(input string tag, input logic [7:0] es, input logic [7:0] em,
                         input logic [7:0] eh, input logic ep);
        n_run++;
        if (sec_bcd !== es || min_bcd !== em || hour_bcd !== eh || pm !== ep) begin
            n_fail++;
            $display("FAIL %s: got %h:%h:%h pm=%b expected %h:%h:%h pm=%b",
                     tag, hour_bcd, min_bcd, sec_bcd, pm, eh, em, es, ep);
        end
    endtask

    task automatic drive(input logic t, input logic [3:0] ce, input logic [3:0] cl,
                         input logic [3:0] ld, input logic [7:0] d);
        tick_1hz = t; stage_ce = ce; stage_clr = cl; stage_ld = ld; load_data = d;
        @(negedge clk);
        tick_1hz = 1'b0; stage_clr = 4'h0; stage_ld = 4'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 8'h00, 8'h00, 8'h12, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].tick, VEC[i].ce, VEC[i].clr, VEC[i].ld, VEC[i].data);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].es, VEC[i].em, VEC[i].eh, VEC[i].ep);
        end

        // R1: reset in the middle of a run
        drive(1'b0, 4'hF, 4'h0, 4'h4, 8'h07);
        drive(1'b0, 4'hF, 4'h0, 4'h8, 8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset", 8'h00, 8'h00, 8'h12, 1'b0);

        // R4 R5: 3661 continuous seconds from 12:00:00 AM
        tick_1hz = 1'b1; stage_ce = 4'hF;
        repeat (3661) @(negedge clk);
        check("R4 1h1m1s", 8'h01, 8'h01, 8'h01, 1'b0);

        // R6: the rest of twelve hours lands on 12:00:00 PM
        repeat (43200 - 3661) @(negedge clk);
        check("R6 half day", 8'h00, 8'h00, 8'h12, 1'b1);
        tick_1hz = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule